// File: doc/BRIEF.md
# Two-Stage Card Clock Divider with Stop Gates

This block makes the clock enables for a storage-card interface from a fast reference clock. Division comes from two cascaded stages. A power-of-two source stage divides by 1, 2, 4, 8 or 16. A final stage then divides by 2 or 4. The total divide therefore runs from 2 to 64. The block produces two single-cycle enable pulses. `card_clk_en` marks the end of each full output period. `fast_clk_en` marks each period of the intermediate, source-divided clock. Each enable has its own stop gate.

Software writes one 10-bit setting word through `cfg_wr`/`cfg_wdata`. It can also raise `stop_req` or `start_req` to turn the clock off or back on. A written word whose divider codes are out of range is rejected. The previous setting stays in force and `cfg_err` pulses. Accepted words and start/stop requests land in a staged copy first. That copy moves into the active setting only on the last reference cycle of an output period, so the output never shows a cut-short period. All ports are plain control and status pins with no handshake. The block always accepts a request and never stalls.

Top module: `cdiv_sd_top`

## Requirements
- R1: After reset, `cfg_active` reads 0x301, which is source code 0, final code 1 (divide by 4) and both stop bits set. `card_clk_en`, `fast_clk_en`, `clk_running` and `cfg_err` are all 0.
- R2: When bit 8 of `cfg_active` is 0, `card_clk_en` pulses for one cycle once every S*F reference cycles. S = 2^(bits 4:2), and F is 2 when bits 1:0 are 0 and 4 when they are 1.
- R3: When bit 9 of `cfg_active` is 0, `fast_clk_en` pulses once every S reference cycles, and it pulses in every cycle where `card_clk_en` is set.
- R4: Bit 8 set holds `card_clk_en` at 0. Bit 9 set holds `fast_clk_en` at 0. Each gate works on its own.
- R5: `clk_running` is 1 exactly when bits 9 and 8 of `cfg_active` are both 0.
- R6: A `stop_req` sets both stop bits of the staged setting and leaves the divider codes unchanged.
- R7: A `start_req` clears bit 8 of the staged setting. It sets bit 9 when the source code is 2, 3 or 4 and clears it when the code is 0 or 1.
- R8: A write is rejected when bits 4:2 exceed 4 or bits 1:0 exceed 1. A rejected write leaves the staged setting unchanged and raises `cfg_err` for the one following cycle. Bits 7:5 are not stored and read 0.
- R9: The staged setting enters `cfg_active` only on the final reference cycle of an output period. The period counter then restarts at zero with the new division.
- R10: In the same cycle, a write takes priority over both requests, and `stop_req` takes priority over `start_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the setting word |
| cfg_wdata | input | 10 | Setting word: [9] fast stop, [8] card stop, [4:2] source code, [1:0] final code |
| start_req | input | 1 | Request to restart the clocks with the pattern for the current division |
| stop_req | input | 1 | Request to stop both clocks |
| cfg_active | output | 10 | Setting currently in force |
| card_clk_en | output | 1 | One-cycle enable at the end of each output period |
| fast_clk_en | output | 1 | One-cycle enable for each intermediate clock period |
| clk_running | output | 1 | Both stop bits of the active setting are clear |
| cfg_err | output | 1 | Pulse one cycle after a rejected write |

## Verification
The assertions assume that `cfg_wr`, `start_req` and `stop_req` are synchronous to `clk` and settle before each edge. They also assume that `cfg_wdata` may hold any value, including illegal divider codes and non-zero bits 7:5. The stimulus drives every input on the falling edge. The random words cover the full 10-bit space, so illegal codes appear often. Requests fall on arbitrary cycles, including the boundary cycle, and sometimes arrive together with writes, which exercises the priority rules.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int CFG_W        = 10;
  localparam int PRE_LSB      = 2;
  localparam int PRE_W        = 3;
  localparam int FC_LSB       = 0;
  localparam int FC_W         = 2;
  localparam int STOP_CK_BIT  = 8;
  localparam int STOP_HCK_BIT = 9;
  localparam int PRE_MAX      = 4;
  localparam int FC_MAX       = 1;
  localparam int HCK_PRE_MIN  = 2;
  localparam int CNT_W        = PRE_MAX + 2;

  localparam logic [CFG_W-1:0] KEEP_MASK =
      CFG_W'((1 << STOP_HCK_BIT) | (1 << STOP_CK_BIT) |
             (((1 << PRE_W) - 1) << PRE_LSB) | (((1 << FC_W) - 1) << FC_LSB));
  localparam logic [CFG_W-1:0] RST_CFG =
      CFG_W'((1 << STOP_HCK_BIT) | (1 << STOP_CK_BIT) | (1 << FC_LSB));

  function automatic logic [PRE_W-1:0] pre_code(logic [CFG_W-1:0] c);
    return c[PRE_LSB +: PRE_W];
  endfunction

  function automatic logic [FC_W-1:0] fc_code(logic [CFG_W-1:0] c);
    return c[FC_LSB +: FC_W];
  endfunction

  function automatic logic cfg_legal(logic [CFG_W-1:0] c);
    return (int'(pre_code(c)) <= PRE_MAX) && (int'(fc_code(c)) <= FC_MAX);
  endfunction

  function automatic logic [CNT_W-1:0] period_last(logic [CFG_W-1:0] c);
    int unsigned n;
    n = (32'd1 << pre_code(c)) << ((fc_code(c) == FC_W'(1)) ? 2 : 1);
    return CNT_W'(n - 32'd1);
  endfunction

  function automatic logic [CNT_W-1:0] src_mask(logic [CFG_W-1:0] c);
    return CNT_W'((32'd1 << pre_code(c)) - 32'd1);
  endfunction
endpackage

// File: rtl/cdiv_shadow.sv
module cdiv_shadow
  import cdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  input  logic             start_req,
  input  logic             stop_req,
  output logic [CFG_W-1:0] staged,
  output logic             err
);
  logic [CFG_W-1:0] staged_d;
  logic             err_d;

  always_comb begin
    staged_d = staged;
    err_d    = 1'b0;
    if (wr) begin
      if (cfg_legal(wdata)) staged_d = wdata & KEEP_MASK;
      else                  err_d    = 1'b1;
    end else if (stop_req) begin
      staged_d[STOP_HCK_BIT] = 1'b1;
      staged_d[STOP_CK_BIT]  = 1'b1;
    end else if (start_req) begin
      staged_d[STOP_CK_BIT]  = 1'b0;
      staged_d[STOP_HCK_BIT] = (int'(pre_code(staged)) >= HCK_PRE_MIN);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged <= RST_CFG;
      err    <= 1'b0;
    end else begin
      staged <= staged_d;
      err    <= err_d;
    end
  end

  // R8: a rejected write leaves the staged word untouched
  a_r8_err_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $stable(staged));
  // R6: stop request sets both gates
  a_r6_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !wr) |=> (staged[STOP_HCK_BIT] && staged[STOP_CK_BIT]));
  // R7: start request restores the pattern for the division
  a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !stop_req && !wr) |=> (!staged[STOP_CK_BIT] &&
      (staged[STOP_HCK_BIT] == (int'(pre_code(staged)) >= HCK_PRE_MIN))));
endmodule

// File: rtl/cdiv_timebase.sv
module cdiv_timebase
  import cdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] staged,
  output logic [CFG_W-1:0] active,
  output logic             card_en,
  output logic             fast_en
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] smask;
  logic             at_end;

  assign last   = period_last(active);
  assign smask  = src_mask(active);
  assign at_end = (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= RST_CFG;
    end else if (at_end) begin
      cnt    <= '0;
      active <= staged;
    end else begin
      cnt    <= cnt + CNT_W'(1);
    end
  end

  assign card_en = at_end && !active[STOP_CK_BIT];
  assign fast_en = ((cnt & smask) == smask) && !active[STOP_HCK_BIT];

  // R9: the active word changes only after a period end
  a_r9_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active) |-> $past(at_end));
  // R8: the active word always holds legal codes
  a_r8_act_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_legal(active));
  // R9: counter restarts after a period end
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    at_end |=> (cnt == '0));
endmodule

// File: rtl/cdiv_sd_top.sv
module cdiv_sd_top
  import cdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             start_req,
  input  logic             stop_req,
  output logic [CFG_W-1:0] cfg_active,
  output logic             card_clk_en,
  output logic             fast_clk_en,
  output logic             clk_running,
  output logic             cfg_err
);
  logic [CFG_W-1:0] staged;

  cdiv_shadow u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (cfg_wr),
    .wdata     (cfg_wdata),
    .start_req (start_req),
    .stop_req  (stop_req),
    .staged    (staged),
    .err       (cfg_err)
  );

  cdiv_timebase u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .staged  (staged),
    .active  (cfg_active),
    .card_en (card_clk_en),
    .fast_en (fast_clk_en)
  );

  assign clk_running = !cfg_active[STOP_HCK_BIT] && !cfg_active[STOP_CK_BIT];

  // R2: minimum division is 2, so no back-to-back card pulses
  a_r2_no_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    card_clk_en |=> !card_clk_en);
  // R3: a card pulse coincides with a fast pulse when the fast gate is open
  a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (card_clk_en && !cfg_active[STOP_HCK_BIT]) |-> fast_clk_en);
  // R5: running clock implies an open card gate
  a_r5_running: assert property (@(posedge clk) disable iff (!rst_n)
    clk_running |-> !cfg_active[STOP_CK_BIT]);
endmodule

// File: tb/cdiv_sd_top_tb.sv
module cdiv_sd_top_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [9:0] cfg_wdata = '0;
  logic       start_req = 1'b0;
  logic       stop_req = 1'b0;
  logic [9:0] cfg_active;
  logic       card_clk_en, fast_clk_en, clk_running, cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [9:0] m_shd, m_act;
  int         m_cnt;
  logic       m_err;

  always #(CLK_P/2) clk = ~clk;

  cdiv_sd_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .start_req(start_req), .stop_req(stop_req), .cfg_active(cfg_active),
    .card_clk_en(card_clk_en), .fast_clk_en(fast_clk_en),
    .clk_running(clk_running), .cfg_err(cfg_err)
  );

  function automatic bit legal(logic [9:0] c);
    return (c[4:2] <= 3'd4) && (c[1:0] <= 2'd1);
  endfunction

  function automatic int period(logic [9:0] c);
    return (1 << c[4:2]) * ((c[1:0] == 2'd1) ? 4 : 2);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [9:0] nshd;
    logic       nerr;
    nshd = m_shd;
    nerr = 1'b0;
    if (!rst_n) begin
      m_shd = 10'h301; m_act = 10'h301; m_cnt = 0; m_err = 1'b0;
      return;
    end
    if (cfg_wr) begin
      if (legal(cfg_wdata)) nshd = cfg_wdata & 10'h31F;
      else nerr = 1'b1;
    end else if (stop_req) nshd[9:8] = 2'b11;
    else if (start_req) begin
      nshd[8] = 1'b0;
      nshd[9] = (m_shd[4:2] >= 3'd2);
    end
    if (m_cnt == period(m_act) - 1) begin
      m_act = m_shd; m_cnt = 0;
    end else m_cnt++;
    m_shd = nshd;
    m_err = nerr;
  endtask

  task automatic compare();
    int s;
    bit e_card, e_fast;
    s = 1 << m_act[4:2];
    e_card = (m_cnt == period(m_act) - 1) && !m_act[8];
    e_fast = ((m_cnt % s) == s - 1) && !m_act[9];
    chk("R9 active word", cfg_active, m_act);
    chk("R2 card enable", card_clk_en, e_card);
    chk("R3 fast enable", fast_clk_en, e_fast);
    chk("R5 running", clk_running, (m_act[9:8] == 2'b00));
    chk("R8 error pulse", cfg_err, m_err);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    cfg_wr = 1'b0; start_req = 1'b0; stop_req = 1'b0;
  endtask

  task automatic settle();
    idle();
    repeat (140) tick();
  endtask

  initial begin
    int cnt_card, cnt_fast;
    void'($urandom(32'd4242));
    repeat (3) tick();
    // R1 reset state
    chk("R1 reset word", cfg_active, 10'h301);
    chk("R1 reset card", card_clk_en, 0);
    chk("R1 reset fast", fast_clk_en, 0);
    chk("R1 reset running", clk_running, 0);
    chk("R1 reset err", cfg_err, 0);
    rst_n = 1'b1;
    tick();
    // R7 start with source code 0
    start_req = 1'b1; tick(); settle();
    chk("R7 start pattern low code", cfg_active, 10'h001);
    // R7 start with source code 3 sets fast stop
    cfg_wr = 1'b1; cfg_wdata = 10'h30C; tick(); idle();
    start_req = 1'b1; tick(); settle();
    chk("R7 start pattern high code", cfg_active, 10'h20C);
    // R6 stop
    stop_req = 1'b1; tick(); settle();
    chk("R6 stop keeps codes", cfg_active, 10'h30C);
    // R10 write beats stop
    cfg_wr = 1'b1; cfg_wdata = 10'h005; stop_req = 1'b1; tick(); settle();
    chk("R10 write priority", cfg_active, 10'h005);
    // R10 stop beats start
    stop_req = 1'b1; start_req = 1'b1; tick(); settle();
    chk("R10 stop over start", cfg_active, 10'h305);
    cfg_wr = 1'b1; cfg_wdata = 10'h0E5; tick(); settle();
    chk("R8 bits 7:5 dropped", cfg_active, 10'h005);
    // R8 illegal codes rejected
    cfg_wr = 1'b1; cfg_wdata = 10'h01D; tick(); idle();
    chk("R8 err after bad source", cfg_err, 1);
    cfg_wr = 1'b1; cfg_wdata = 10'h006; tick(); idle();
    chk("R8 err after bad final", cfg_err, 1);
    settle();
    chk("R8 setting retained", cfg_active, 10'h005);
    // R4 card gate alone
    cfg_wr = 1'b1; cfg_wdata = 10'h105; tick(); settle();
    cnt_card = 0; cnt_fast = 0;
    for (int i = 0; i < 64; i++) begin
      tick();
      cnt_card += card_clk_en;
      cnt_fast += fast_clk_en;
    end
    chk("R4 card gated", cnt_card, 0);
    chk("R4 fast free", cnt_fast, 32);
    // R4 fast gate alone, R2 count at divide 8
    cfg_wr = 1'b1; cfg_wdata = 10'h205; tick(); settle();
    cnt_card = 0; cnt_fast = 0;
    for (int i = 0; i < 64; i++) begin
      tick();
      cnt_card += card_clk_en;
      cnt_fast += fast_clk_en;
    end
    chk("R4 fast gated", cnt_fast, 0);
    chk("R2 divide 8 count", cnt_card, 8);
    // random phase
    for (int i = 0; i < 8000; i++) begin
      cfg_wr    = ($urandom_range(0, 15) == 0);
      cfg_wdata = 10'($urandom());
      if ($urandom_range(0, 2) != 0) cfg_wdata[9:8] = 2'b00;
      stop_req  = ($urandom_range(0, 39) == 0);
      start_req = ($urandom_range(0, 19) == 0);
      tick();
    end
    idle();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule